// File: doc/BRIEF.md
# Write/Read Port Parity Guard with Port-0 Delay Line

This block sits between the outside world and a sliced vector register array. It takes the raw request buses of five read ports and three write ports, checks parity on every write byte and on the address and control fields, and records each detected error in a sticky flag. The flags stay set until software-independent logic upstream pulses a synchronous clear.

The same block can hold back write port 0. A 2-bit delay code shifts the whole port-0 write by zero to three clock cycles: enable, register select, element address and data move together. The upstream scheduler uses this shift to move a write away from a register access that would otherwise collide with it. All other ports go through unchanged and with no added latency.

The reset input is asynchronous and active low. Inside the block it passes through a two-stage synchronizer, so the internal reset is released on the second rising clock edge after the input goes high.

Top module: `vec_port_frontend`

## Requirements
- R1: While reset is held, all data and group error flags read 0, and the delayed port-0 enable output reads 0 for any non-zero delay code.
- R2: Write data is 9 bits per port, byte in bits 7:0 and parity in bit 8, and uses odd parity. If an enabled write port k presents an even number of ones, o_data_err[k] is 1 after the next rising edge.
- R3: Three control groups each carry odd parity. Group 0 is read ports 0-2, group 1 is read ports 3-4 and group 2 is write ports 0-2. A group covers the enable bit of each of its ports, the select and address bits of its enabled ports, and its bit of i_grp_par. When any port in the group is enabled and the covered bits hold an even count of ones, o_grp_err[g] is 1 after the next rising edge.
- R4: A disabled port never sets a flag. Its data parity is ignored, and the select and address of a disabled port do not enter its group check. A group with no enabled port is not checked at all.
- R5: Once set, an error flag stays set for as long as i_err_clr stays low.
- R6: When i_err_clr is high at a rising edge, every flag is cleared, except that an error detected in that same cycle sets its own flag anyway.
- R7: With delay code 0, the port-0 write outputs equal the port-0 write inputs in the same cycle.
- R8: With delay code N in 1..3, o_wr_en[0], o_wr_sel, o_wr_addr and o_wr_data for port 0 equal the values sampled at the rising edge N cycles earlier. Changing the code changes only which earlier sample is shown.
- R9: All read ports and write ports 1 and 2 pass to the outputs unchanged, within the same cycle.
- R10: Each flag responds only to its own port or group. An error on one write port sets no other data flag and no group flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_rd_en | input | 5 | Read port enables |
| i_rd_sel | input | 20 | Read register selects, 4 bits per port |
| i_rd_addr | input | 30 | Read element addresses, 6 bits per port |
| i_wr_en | input | 3 | Write port enables |
| i_wr_sel | input | 12 | Write register selects, 4 bits per port |
| i_wr_addr | input | 18 | Write element addresses, 6 bits per port |
| i_wr_data | input | 27 | Write data, 9 bits per port (parity in bit 8) |
| i_grp_par | input | 3 | Incoming parity bit per control group |
| i_dly_sel | input | 2 | Port-0 delay code, 0 to 3 cycles |
| i_err_clr | input | 1 | Synchronous clear of all error flags |
| o_rd_en | output | 5 | Read enables, passed through |
| o_rd_sel | output | 20 | Read selects, passed through |
| o_rd_addr | output | 30 | Read addresses, passed through |
| o_wr_en | output | 3 | Write enables, port 0 delayed |
| o_wr_sel | output | 12 | Write selects, port 0 delayed |
| o_wr_addr | output | 18 | Write addresses, port 0 delayed |
| o_wr_data | output | 27 | Write data, port 0 delayed |
| o_data_err | output | 3 | Sticky data parity error per write port |
| o_grp_err | output | 3 | Sticky control parity error per group |

## Verification
The assertions assume only that all inputs carry known values once the internal reset has been released. They assume nothing about parity correctness, how long the clear is held, or when the delay code changes, so every combination of these is legal input. The stimulus drives all inputs at the falling edge. It holds them at zero while the synchronized reset is still pending, which keeps the delay stages and the bench's own history of port-0 samples in step. Parity is generated correctly by default, and errors are injected at a low rate, so the flags both build up and get cleared many times.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int VPF_RD_PORTS = 5;
  localparam int VPF_WR_PORTS = 3;
  localparam int VPF_SEL_W    = 4;
  localparam int VPF_ADDR_W   = 6;
  localparam int VPF_BYTE_W   = 8;
  localparam int VPF_RD_SPLIT = 3;   // read ports below this index form group 0
  localparam int VPF_MAX_DLY  = 3;
  localparam int VPF_DLY_W    = $clog2(VPF_MAX_DLY + 1);

  typedef enum logic [1:0] {
    DLY_BYPASS = 2'd0,
    DLY_ONE    = 2'd1,
    DLY_TWO    = 2'd2,
    DLY_THREE  = 2'd3
  } vpf_dly_e;
endpackage

// File: rtl/vpf_rst_sync.sv
module vpf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vpf_parity_flag.sv
module vpf_parity_flag #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] bits,
  input  logic         clr,
  output logic         flag
);
  logic odd_ok;
  logic hit;
  logic flag_d;
  logic flag_q;

  always_comb begin
    odd_ok = ^bits;
    hit    = active && !odd_ok;
    flag_d = (clr ? 1'b0 : flag_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R2 (data ports) and R3 (groups): even count on an active check sets the flag
  a_r2_even_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(^bits)) |=> flag);

  // R5: a set flag survives while clear is low
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R6: clear with no simultaneous error empties the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(active && !(^bits))) |=> !flag);

  // R4: an inactive check leaves the flag where it was
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> $stable(flag));
endmodule

// File: rtl/vpf_delay_line.sv
module vpf_delay_line
  import vpf_pkg::*;
#(
  parameter int W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VPF_DLY_W-1:0] dly_sel,
  input  logic [W-1:0]         din,
  output logic [W-1:0]         dout
);
  logic [W-1:0] stage_q [VPF_MAX_DLY];
  logic [W-1:0] stage_d [VPF_MAX_DLY];
  logic [1:0]   fill_q;
  logic [1:0]   fill_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < VPF_MAX_DLY; i++) stage_d[i] = stage_q[i-1];
    fill_d = (fill_q == 2'd3) ? fill_q : fill_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VPF_MAX_DLY; i++) stage_q[i] <= '0;
      fill_q <= 2'd0;
    end else begin
      for (int i = 0; i < VPF_MAX_DLY; i++) stage_q[i] <= stage_d[i];
      fill_q <= fill_d;
    end
  end

  always_comb begin
    dout = din;
    for (int i = 0; i < VPF_MAX_DLY; i++)
      if (dly_sel == VPF_DLY_W'(i + 1)) dout = stage_q[i];
  end

  // R8: each tap shows the input of exactly N edges ago once that history exists
  a_r8_tap_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q >= 2'd1 && dly_sel == VPF_DLY_W'(1)) |-> (dout == $past(din, 1)));

  a_r8_tap_two: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q >= 2'd2 && dly_sel == VPF_DLY_W'(2)) |-> (dout == $past(din, 2)));

  a_r8_tap_three: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd3 && dly_sel == VPF_DLY_W'(3)) |-> (dout == $past(din, 3)));
endmodule

// File: rtl/vec_port_frontend.sv
module vec_port_frontend
  import vpf_pkg::*;
#(
  parameter int NUM_RD   = VPF_RD_PORTS,
  parameter int NUM_WR   = VPF_WR_PORTS,
  parameter int SEL_W    = VPF_SEL_W,
  parameter int ADDR_W   = VPF_ADDR_W,
  parameter int BYTE_W   = VPF_BYTE_W,
  parameter int RD_SPLIT = VPF_RD_SPLIT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_RD-1:0]           i_rd_en,
  input  logic [NUM_RD*SEL_W-1:0]     i_rd_sel,
  input  logic [NUM_RD*ADDR_W-1:0]    i_rd_addr,
  input  logic [NUM_WR-1:0]           i_wr_en,
  input  logic [NUM_WR*SEL_W-1:0]     i_wr_sel,
  input  logic [NUM_WR*ADDR_W-1:0]    i_wr_addr,
  input  logic [NUM_WR*(BYTE_W+1)-1:0] i_wr_data,
  input  logic [2:0]                  i_grp_par,
  input  logic [VPF_DLY_W-1:0]        i_dly_sel,
  input  logic                        i_err_clr,
  output logic [NUM_RD-1:0]           o_rd_en,
  output logic [NUM_RD*SEL_W-1:0]     o_rd_sel,
  output logic [NUM_RD*ADDR_W-1:0]    o_rd_addr,
  output logic [NUM_WR-1:0]           o_wr_en,
  output logic [NUM_WR*SEL_W-1:0]     o_wr_sel,
  output logic [NUM_WR*ADDR_W-1:0]    o_wr_addr,
  output logic [NUM_WR*(BYTE_W+1)-1:0] o_wr_data,
  output logic [NUM_WR-1:0]           o_data_err,
  output logic [2:0]                  o_grp_err
);
  localparam int DW      = BYTE_W + 1;
  localparam int SLOT_W  = 1 + SEL_W + ADDR_W + DW;
  localparam int NUM_GRP = 3;
  localparam int G_RD_LO = 0;
  localparam int G_RD_HI = 1;
  localparam int G_WR    = 2;

  logic rst_core_n;

  vpf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Read ports are not retimed
  assign o_rd_en   = i_rd_en;
  assign o_rd_sel  = i_rd_sel;
  assign o_rd_addr = i_rd_addr;

  // Control-group parity folds: enables always, fields only of enabled ports
  logic [NUM_GRP-1:0] grp_act;
  logic [NUM_GRP-1:0] grp_fold;

  always_comb begin
    grp_act  = '0;
    grp_fold = '0;
    for (int i = 0; i < NUM_RD; i++) begin
      if (i < RD_SPLIT) begin
        grp_act[G_RD_LO]  = grp_act[G_RD_LO] | i_rd_en[i];
        grp_fold[G_RD_LO] = grp_fold[G_RD_LO] ^ i_rd_en[i] ^
          (i_rd_en[i] & ((^i_rd_sel[i*SEL_W +: SEL_W]) ^ (^i_rd_addr[i*ADDR_W +: ADDR_W])));
      end else begin
        grp_act[G_RD_HI]  = grp_act[G_RD_HI] | i_rd_en[i];
        grp_fold[G_RD_HI] = grp_fold[G_RD_HI] ^ i_rd_en[i] ^
          (i_rd_en[i] & ((^i_rd_sel[i*SEL_W +: SEL_W]) ^ (^i_rd_addr[i*ADDR_W +: ADDR_W])));
      end
    end
    for (int k = 0; k < NUM_WR; k++) begin
      grp_act[G_WR]  = grp_act[G_WR] | i_wr_en[k];
      grp_fold[G_WR] = grp_fold[G_WR] ^ i_wr_en[k] ^
        (i_wr_en[k] & ((^i_wr_sel[k*SEL_W +: SEL_W]) ^ (^i_wr_addr[k*ADDR_W +: ADDR_W])));
    end
    grp_fold = grp_fold ^ i_grp_par;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
    vpf_parity_flag #(.W(1)) u_grp_flag (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .active (grp_act[g]),
      .bits   (grp_fold[g]),
      .clr    (i_err_clr),
      .flag   (o_grp_err[g])
    );
  end

  for (genvar k = 0; k < NUM_WR; k++) begin : g_wr_port
    vpf_parity_flag #(.W(DW)) u_data_flag (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .active (i_wr_en[k]),
      .bits   (i_wr_data[k*DW +: DW]),
      .clr    (i_err_clr),
      .flag   (o_data_err[k])
    );

    if (k == 0) begin : g_delayed
      logic [SLOT_W-1:0] slot_in;
      logic [SLOT_W-1:0] slot_out;

      assign slot_in = {i_wr_en[0], i_wr_sel[0 +: SEL_W], i_wr_addr[0 +: ADDR_W], i_wr_data[0 +: DW]};

      vpf_delay_line #(.W(SLOT_W)) u_dly (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .dly_sel (i_dly_sel),
        .din     (slot_in),
        .dout    (slot_out)
      );

      assign {o_wr_en[0], o_wr_sel[0 +: SEL_W], o_wr_addr[0 +: ADDR_W], o_wr_data[0 +: DW]} = slot_out;
    end else begin : g_direct
      assign o_wr_en[k]                  = i_wr_en[k];
      assign o_wr_sel[k*SEL_W +: SEL_W]   = i_wr_sel[k*SEL_W +: SEL_W];
      assign o_wr_addr[k*ADDR_W +: ADDR_W] = i_wr_addr[k*ADDR_W +: ADDR_W];
      assign o_wr_data[k*DW +: DW]        = i_wr_data[k*DW +: DW];
    end
  end
endmodule

// File: tb/vec_port_frontend_bench.sv
`timescale 1ns/100ps
module vec_port_frontend_bench;
  localparam int RD = 5, WR = 3, SW = 4, AW = 6, DW = 9, SPLIT = 3, BW = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [RD-1:0]    rd_en;
  logic [RD*SW-1:0] rd_sel;
  logic [RD*AW-1:0] rd_addr;
  logic [WR-1:0]    wr_en;
  logic [WR*SW-1:0] wr_sel;
  logic [WR*AW-1:0] wr_addr;
  logic [WR*DW-1:0] wr_data;
  logic [2:0]       grp_par;
  logic [1:0]       dly_sel;
  logic             err_clr;
  logic [RD-1:0]    o_rd_en;
  logic [RD*SW-1:0] o_rd_sel;
  logic [RD*AW-1:0] o_rd_addr;
  logic [WR-1:0]    o_wr_en;
  logic [WR*SW-1:0] o_wr_sel;
  logic [WR*AW-1:0] o_wr_addr;
  logic [WR*DW-1:0] o_wr_data;
  logic [WR-1:0]    o_data_err;
  logic [2:0]       o_grp_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [BW-1:0] hist [3];
  logic [WR-1:0] exp_derr;
  logic [2:0]    exp_gerr;

  always #2.5 clk = ~clk;

  vec_port_frontend u_vec_port_frontend (
    .clk(clk), .rst_n(rst_n),
    .i_rd_en(rd_en), .i_rd_sel(rd_sel), .i_rd_addr(rd_addr),
    .i_wr_en(wr_en), .i_wr_sel(wr_sel), .i_wr_addr(wr_addr), .i_wr_data(wr_data),
    .i_grp_par(grp_par), .i_dly_sel(dly_sel), .i_err_clr(err_clr),
    .o_rd_en(o_rd_en), .o_rd_sel(o_rd_sel), .o_rd_addr(o_rd_addr),
    .o_wr_en(o_wr_en), .o_wr_sel(o_wr_sel), .o_wr_addr(o_wr_addr), .o_wr_data(o_wr_data),
    .o_data_err(o_data_err), .o_grp_err(o_grp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic grp_fold(input int g);
    logic f = 1'b0;
    for (int i = 0; i < RD; i++)
      if ((i < SPLIT && g == 0) || (i >= SPLIT && g == 1)) begin
        f ^= rd_en[i];
        if (rd_en[i]) f ^= (^rd_sel[i*SW +: SW]) ^ (^rd_addr[i*AW +: AW]);
      end
    if (g == 2)
      for (int k = 0; k < WR; k++) begin
        f ^= wr_en[k];
        if (wr_en[k]) f ^= (^wr_sel[k*SW +: SW]) ^ (^wr_addr[k*AW +: AW]);
      end
    return f;
  endfunction

  function automatic logic grp_active(input int g);
    if (g == 0) return |rd_en[SPLIT-1:0];
    if (g == 1) return |rd_en[RD-1:SPLIT];
    return |wr_en;
  endfunction

  function automatic logic [BW-1:0] slot_in();
    return {wr_en[0], wr_sel[SW-1:0], wr_addr[AW-1:0], wr_data[DW-1:0]};
  endfunction

  task automatic zero_in();
    rd_en = '0; rd_sel = '0; rd_addr = '0;
    wr_en = '0; wr_sel = '0; wr_addr = '0; wr_data = '0;
    grp_par = '0; err_clr = 1'b0;
  endtask

  task automatic fix_grp_par();
    for (int g = 0; g < 3; g++) grp_par[g] = ~grp_fold(g);
  endtask

  task automatic set_wr(input int k, input bit en, input bit good);
    logic [7:0] b = 8'($urandom);
    wr_en[k] = en;
    wr_sel[k*SW +: SW] = 4'($urandom);
    wr_addr[k*AW +: AW] = 6'($urandom);
    wr_data[k*DW +: DW] = {(~^b) ^ !good, b};
  endtask

  task automatic rnd_in();
    for (int i = 0; i < RD; i++) begin
      rd_en[i] = 1'($urandom);
      rd_sel[i*SW +: SW] = 4'($urandom);
      rd_addr[i*AW +: AW] = 6'($urandom);
    end
    for (int k = 0; k < WR; k++) set_wr(k, 1'($urandom), ($urandom % 16) != 0);
    fix_grp_par();
    for (int g = 0; g < 3; g++) if (($urandom % 16) == 0) grp_par[g] = ~grp_par[g];
    err_clr = (($urandom % 20) == 0);
  endtask

  // One clock: inputs already driven after a falling edge
  task automatic cycle();
    logic [BW-1:0] e0;
    logic [WR-1:0] nd;
    logic [2:0]    ng;
    #1;
    chk({o_rd_en, o_rd_sel, o_rd_addr} == {rd_en, rd_sel, rd_addr}, "R9 read pass",
        64'({o_rd_en, o_rd_sel, o_rd_addr}), 64'({rd_en, rd_sel, rd_addr}));
    chk({o_wr_en[2:1], o_wr_sel[11:4], o_wr_addr[17:6], o_wr_data[26:9]} ==
        {wr_en[2:1], wr_sel[11:4], wr_addr[17:6], wr_data[26:9]}, "R9 write pass",
        64'({o_wr_en[2:1], o_wr_sel[11:4], o_wr_addr[17:6], o_wr_data[26:9]}),
        64'({wr_en[2:1], wr_sel[11:4], wr_addr[17:6], wr_data[26:9]}));
    e0 = (dly_sel == 2'd0) ? slot_in() : hist[dly_sel - 2'd1];
    chk({o_wr_en[0], o_wr_sel[3:0], o_wr_addr[5:0], o_wr_data[8:0]} == e0,
        (dly_sel == 2'd0) ? "R7 bypass" : "R8 delayed port 0",
        64'({o_wr_en[0], o_wr_sel[3:0], o_wr_addr[5:0], o_wr_data[8:0]}), 64'(e0));
    for (int k = 0; k < WR; k++)
      nd[k] = (err_clr ? 1'b0 : exp_derr[k]) | (wr_en[k] && !(^wr_data[k*DW +: DW]));
    for (int g = 0; g < 3; g++)
      ng[g] = (err_clr ? 1'b0 : exp_gerr[g]) | (grp_active(g) && !(grp_fold(g) ^ grp_par[g]));
    @(posedge clk);
    exp_derr = nd;
    exp_gerr = ng;
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = slot_in();
    @(negedge clk);
    chk(o_data_err == exp_derr, "R2 data flags", 64'(o_data_err), 64'(exp_derr));
    chk(o_grp_err == exp_gerr, "R3 group flags", 64'(o_grp_err), 64'(exp_gerr));
  endtask

  initial begin
    void'($urandom(32'h1F3A_5C07));
    for (int i = 0; i < 3; i++) hist[i] = '0;
    exp_derr = '0;
    exp_gerr = '0;
    // R1: reset holds flags and delay stages clear even with bad enabled inputs
    rst_n = 1'b0;
    zero_in();
    dly_sel = 2'd1;
    wr_en = 3'b111;
    rd_en = 5'b11111;
    grp_par = 3'b000;
    repeat (3) @(negedge clk);
    chk(o_data_err == 3'b000, "R1 data flags in reset", 64'(o_data_err), 64'd0);
    chk(o_grp_err == 3'b000, "R1 group flags in reset", 64'(o_grp_err), 64'd0);
    chk(o_wr_en[0] == 1'b0, "R1 delayed enable in reset", 64'(o_wr_en[0]), 64'd0);
    zero_in();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: disabled ports with bad parity and stray fields
    zero_in();
    set_wr(1, 1'b0, 1'b0);
    rd_sel = 20'hFFFFF;
    grp_par = 3'b000;
    cycle();
    chk(o_data_err == 3'b000, "R4 disabled data ignored", 64'(o_data_err), 64'd0);
    chk(o_grp_err == 3'b000, "R4 idle groups ignored", 64'(o_grp_err), 64'd0);

    // R10: only the faulty port's flag rises
    zero_in();
    set_wr(0, 1'b1, 1'b1);
    set_wr(1, 1'b1, 1'b1);
    set_wr(2, 1'b1, 1'b0);
    fix_grp_par();
    cycle();
    chk(o_data_err == 3'b100, "R10 isolated data flag", 64'(o_data_err), 64'h4);
    chk(o_grp_err == 3'b000, "R10 no group flag", 64'(o_grp_err), 64'd0);

    // R5: flag persists with quiet inputs
    zero_in();
    repeat (3) cycle();
    chk(o_data_err == 3'b100, "R5 sticky", 64'(o_data_err), 64'h4);

    // R6: clear alone, then clear with a simultaneous error
    zero_in();
    err_clr = 1'b1;
    cycle();
    chk(o_data_err == 3'b000, "R6 clear", 64'(o_data_err), 64'd0);
    set_wr(0, 1'b1, 1'b0);
    fix_grp_par();
    err_clr = 1'b1;
    cycle();
    chk(o_data_err == 3'b001, "R6 set beats clear", 64'(o_data_err), 64'h1);

    // R3: a group error on read group 1 only
    zero_in();
    rd_en[4] = 1'b1;
    rd_sel[16 +: 4] = 4'h3;
    fix_grp_par();
    grp_par[1] = ~grp_par[1];
    err_clr = 1'b1;
    cycle();
    chk(o_grp_err == 3'b010, "R3 group one error", 64'(o_grp_err), 64'h2);

    // R7, R8: sweep every delay code under random traffic
    for (int d = 0; d < 4; d++) begin
      dly_sel = 2'(d);
      repeat (40) begin
        rnd_in();
        cycle();
      end
    end

    // Mixed random run with delay code changing mid-stream
    for (int n = 0; n < 1500; n++) begin
      if ((n % 37) == 0) dly_sel = 2'($urandom);
      rnd_in();
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule